// File: doc/BRIEF.md
# Cluster Transfer Address Sequencer

This block turns one programmed cluster-mode DMA transfer into a string of bus requests. A single `start` pulse loads the start address, the byte count, the access size, the cluster size, the address update mode, an address offset and the error-interrupt enable. The block then presents one request at a time, with its address and size, over a valid/ready handshake. After each accepted request it moves to the next address and reduces the count of bytes left.

In increment mode a start address that is off the access-size boundary is reached in smaller cycles. Once the address is aligned, cycles run at full size. Any tail shorter than the access size is split again. In the other three modes the low address bits are cleared at load and every cycle runs at full size.

A byte count below the cluster size is a transfer-size error. If the error-interrupt enable is set, the transfer is dropped and a sticky flag is raised. If it is clear, the transfer runs in block-style fallback. In fallback the address is used unmasked and is split by alignment in every mode.

Top module: `clusterAddrSeq`

## Requirements
- R1: After reset `reqValid`, `busy`, `done` and `sizeErr` are all low.
- R2: `cfgSize` encodes the access size: 0 is a byte, 1 is a word (2 bytes), 2 or 3 is a longword (4 bytes). `cfgMode` encodes the update mode: 0 is increment, 1 is decrement, 2 is fixed, 3 is offset. In increment mode with an aligned start and a count that is a multiple of the size, every request has `reqSize` equal to the access size, and the address steps by that many bytes.
- R3: In increment mode an unaligned start is brought to the boundary with the largest aligned cycle: a byte (`reqSize`=0) at an odd address, then a word (`reqSize`=1) at an address that is 2 mod 4.
- R4: In increment mode, when fewer bytes remain than the access size, the tail is issued as the largest power-of-two cycles that fit, never passing the byte count.
- R5: In decrement, fixed and offset modes, when no size error occurs, the loaded address has its low bits cleared (1 bit for word, 2 for longword). All cycles are full size. The cycle that reaches or passes the end of the count is the last one.
- R6: After each accepted cycle, decrement subtracts that cycle's byte size from the address, fixed leaves the address as it is, and offset adds `cfgOffset`.
- R7: While `reqValid` is high and `reqReady` is low, `reqAddr` and `reqSize` hold their values. The sequence advances only on an accepted request.
- R8: `done` is high for exactly one cycle, in the cycle after the final request is accepted. In that same cycle `busy` and `reqValid` are low.
- R9: The cluster size is (`cfgClusterUnits`+1) access units. If the count is below it and `cfgErrIe` is 1, no request is issued and `sizeErr` rises in the cycle after `start`. It then stays high until `errClear`. If a new error and `errClear` fall in the same cycle, the flag stays set.
- R10: On a size error with `cfgErrIe` 0, the transfer runs with the unmasked address and cycles split by alignment and remaining count in every mode. The address is updated as in R6.
- R11: A zero count with `cfgErrIe` 0 gives a `done` pulse in the cycle after `start`, with no request.
- R12: A `start` pulse while `busy` is high is ignored, and the running sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load configuration and begin a transfer |
| cfgAddr | input | ADDR_W | Start address |
| cfgCount | input | CNT_W | Transfer length in bytes |
| cfgSize | input | 2 | Access size code |
| cfgClusterUnits | input | CLU_W | Cluster size minus one, in access units |
| cfgMode | input | 2 | Address update mode code |
| cfgOffset | input | ADDR_W | Address step in offset mode |
| cfgErrIe | input | 1 | Abort on size error when set |
| errClear | input | 1 | Clears the size error flag |
| reqValid | output | 1 | Bus request present |
| reqReady | input | 1 | Bus accepts the present request |
| reqAddr | output | ADDR_W | Request address |
| reqSize | output | 2 | Request size code (0 byte, 1 word, 2 longword) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| sizeErr | output | 1 | Sticky transfer-size error flag |

## Verification
Two pairs of events can land in the same cycle. The first is `errClear` together with a new start that raises a size error. The second is a stray `start` while a stalled request waits for `reqReady`. The bench drives both in one negedge slot. It expects the error flag to stay set in the first case. In the second, the cycle-by-cycle reference queue built at the original start must still match every later request.

// File: rtl/clusterSeqPkg.sv
package clusterSeqPkg;

  typedef enum logic [1:0] {
    MODE_INC = 2'd0,
    MODE_DEC = 2'd1,
    MODE_FIX = 2'd2,
    MODE_OFS = 2'd3
  } updMode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic advance;
  } seqStrobe_t;

  // code 3 is treated as longword
  function automatic logic [1:0] clampSize(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/clusterSeqDatapath.sv
module clusterSeqDatapath
  import clusterSeqPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int CLU_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [1:0]        cfgSize,
  input  logic [CLU_W-1:0]  cfgClusterUnits,
  input  logic [1:0]        cfgMode,
  input  logic [ADDR_W-1:0] cfgOffset,
  output logic              underSize,
  output logic              cntZero,
  output logic              lastBeat,
  output logic [ADDR_W-1:0] curAddr,
  output logic [1:0]        curSize
);

  localparam int CMP_W = CNT_W + CLU_W + 3;

  logic [ADDR_W-1:0] addrR;
  logic [CNT_W-1:0]  remR;
  updMode_e          modeR;
  logic [1:0]        accR;
  logic [ADDR_W-1:0] offsetR;
  logic              splitR;

  logic [1:0]        accIn;
  logic [CMP_W-1:0]  clusBytes;
  logic [ADDR_W-1:0] alignMask;
  logic [1:0]        cycLog2;
  logic [CNT_W-1:0]  cycBytes;
  logic [ADDR_W-1:0] cycBytesA;

  // configuration decode for the load cycle
  always_comb begin
    accIn     = clampSize(cfgSize);
    clusBytes = (CMP_W'(cfgClusterUnits) + CMP_W'(1)) << accIn;
    underSize = CMP_W'(cfgCount) < clusBytes;
    cntZero   = (cfgCount == '0);
    alignMask = ~((ADDR_W'(1) << accIn) - ADDR_W'(1));
  end

  // largest cycle that keeps alignment and fits the remaining count
  always_comb begin
    cycLog2 = accR;
    if (splitR) begin
      if (cycLog2 == 2'd2 && (addrR[1:0] != 2'b00 || remR < CNT_W'(4)))
        cycLog2 = 2'd1;
      if (cycLog2 != 2'd0 && (addrR[0] || remR < CNT_W'(2)))
        cycLog2 = 2'd0;
    end
    cycBytes  = CNT_W'(1) << cycLog2;
    cycBytesA = ADDR_W'(1) << cycLog2;
    lastBeat  = (remR <= cycBytes);
  end

  assign curAddr = addrR;
  assign curSize = cycLog2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR   <= '0;
      remR    <= '0;
      modeR   <= MODE_INC;
      accR    <= 2'd0;
      offsetR <= '0;
      splitR  <= 1'b0;
    end else if (strobe.load) begin
      modeR   <= updMode_e'(cfgMode);
      accR    <= accIn;
      offsetR <= cfgOffset;
      remR    <= cfgCount;
      if (updMode_e'(cfgMode) == MODE_INC || underSize) begin
        splitR <= 1'b1;
        addrR  <= cfgAddr;
      end else begin
        splitR <= 1'b0;
        addrR  <= cfgAddr & alignMask;
      end
    end else if (strobe.advance) begin
      remR <= lastBeat ? '0 : remR - cycBytes;
      unique case (modeR)
        MODE_INC: addrR <= addrR + cycBytesA;
        MODE_DEC: addrR <= addrR - cycBytesA;
        MODE_FIX: addrR <= addrR;
        MODE_OFS: addrR <= addrR + offsetR;
        default:  addrR <= addrR;
      endcase
    end
  end

  // R8
  cnt_shrink_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.load) |=> (remR < $past(remR)));

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!splitR && accR == 2'd2 && modeR != MODE_OFS) |-> (addrR[1:0] == 2'b00));

endmodule

// File: rtl/clusterSeqCtrl.sv
module clusterSeqCtrl
  import clusterSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cfgErrIe,
  input  logic       errClear,
  input  logic       underSize,
  input  logic       cntZero,
  input  logic       lastBeat,
  input  logic       reqReady,
  output seqStrobe_t strobe,
  output logic       reqValid,
  output logic       busy,
  output logic       done,
  output logic       sizeErr
);

  seqState_e state;
  logic      errSet;

  always_comb begin
    strobe.load    = start && (state == ST_IDLE);
    strobe.advance = (state == ST_RUN) && reqReady;
    errSet         = strobe.load && underSize && cfgErrIe;
    reqValid       = (state == ST_RUN);
    busy           = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (strobe.load && !errSet) begin
            if (cntZero) done  <= 1'b1;
            else         state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (strobe.advance && lastBeat) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // new error has priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)         sizeErr <= 1'b0;
    else if (errSet)   sizeErr <= 1'b1;
    else if (errClear) sizeErr <= 1'b0;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sizeErr && !errClear) |=> sizeErr);

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sizeErr) |-> !reqValid);

endmodule

// File: rtl/clusterAddrSeq.sv
module clusterAddrSeq
  import clusterSeqPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int CLU_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic [1:0]        cfgSize,
  input  logic [CLU_W-1:0]  cfgClusterUnits,
  input  logic [1:0]        cfgMode,
  input  logic [ADDR_W-1:0] cfgOffset,
  input  logic              cfgErrIe,
  input  logic              errClear,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [1:0]        reqSize,
  output logic              busy,
  output logic              done,
  output logic              sizeErr
);

  seqStrobe_t strobe;
  logic underSize, cntZero, lastBeat;

  clusterSeqCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cfgErrIe (cfgErrIe),
    .errClear (errClear),
    .underSize(underSize),
    .cntZero  (cntZero),
    .lastBeat (lastBeat),
    .reqReady (reqReady),
    .strobe   (strobe),
    .reqValid (reqValid),
    .busy     (busy),
    .done     (done),
    .sizeErr  (sizeErr)
  );

  clusterSeqDatapath #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W),
    .CLU_W (CLU_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .cfgAddr        (cfgAddr),
    .cfgCount       (cfgCount),
    .cfgSize        (cfgSize),
    .cfgClusterUnits(cfgClusterUnits),
    .cfgMode        (cfgMode),
    .cfgOffset      (cfgOffset),
    .underSize      (underSize),
    .cntZero        (cntZero),
    .lastBeat       (lastBeat),
    .curAddr        (reqAddr),
    .curSize        (reqSize)
  );

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr) && $stable(reqSize)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!reqValid && !busy));

endmodule

// File: tb/clusterAddrSeq_bench.sv
module clusterAddrSeq_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [31:0] cfgAddr;
  logic [15:0] cfgCount;
  logic [1:0]  cfgSize;
  logic [2:0]  cfgClusterUnits;
  logic [1:0]  cfgMode;
  logic [31:0] cfgOffset;
  logic        cfgErrIe;
  logic        errClear;
  logic        reqValid;
  logic        reqReady;
  logic [31:0] reqAddr;
  logic [1:0]  reqSize;
  logic        busy;
  logic        done;
  logic        sizeErr;

  int nChecks = 0;
  int nFail   = 0;
  logic [33:0] expQ[$];
  logic [7:0]  lfsr = 8'hA5;

  always #2 clk = ~clk;

  clusterAddrSeq u_clusterAddrSeq (
    .clk(clk), .rstN(rstN), .start(start), .cfgAddr(cfgAddr), .cfgCount(cfgCount),
    .cfgSize(cfgSize), .cfgClusterUnits(cfgClusterUnits), .cfgMode(cfgMode),
    .cfgOffset(cfgOffset), .cfgErrIe(cfgErrIe), .errClear(errClear),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqSize(reqSize),
    .busy(busy), .done(done), .sizeErr(sizeErr)
  );

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R8 watchdog expired act=0 exp=1");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural reference: list of {size, addr} expected for one transfer
  task automatic buildModel(input logic [31:0] a0, input int count, input int szCode,
                            input int units, input int mode, input logic [31:0] off,
                            input bit ie, output bit err);
    int acc, rem, b, lg;
    logic [31:0] a;
    bit split, under;
    expQ.delete();
    acc   = (szCode >= 2) ? 4 : (szCode == 1 ? 2 : 1);
    under = count < (units + 1) * acc;
    err   = under && ie;
    if (err) return;
    split = (mode == 0) || under;
    a     = split ? a0 : (a0 & ~(32'(acc) - 32'd1));
    rem   = count;
    while (rem > 0) begin
      b = acc;
      if (split) while (b > 1 && ((int'(a) % b) != 0 || rem < b)) b = b / 2;
      lg = (b == 4) ? 2 : (b == 2 ? 1 : 0);
      expQ.push_back({2'(lg), a});
      rem = (rem > b) ? rem - b : 0;
      case (mode)
        0: a = a + 32'(b);
        1: a = a - 32'(b);
        3: a = a + off;
        default: ;
      endcase
    end
  endtask

  task automatic setCfg(input logic [31:0] a, input int count, input int szCode,
                        input int units, input int mode, input logic [31:0] off, input bit ie);
    cfgAddr = a; cfgCount = 16'(count); cfgSize = 2'(szCode);
    cfgClusterUnits = 3'(units); cfgMode = 2'(mode); cfgOffset = off; cfgErrIe = ie;
  endtask

  // runs one transfer; called right after a negedge
  task automatic runXfer(input string req, input logic [31:0] a, input int count,
                         input int szCode, input int units, input int mode,
                         input logic [31:0] off, input bit stall, input bit midStart);
    bit err;
    logic [33:0] e;
    int n = 0;
    buildModel(a, count, szCode, units, mode, off, 1'b0, err);
    setCfg(a, count, szCode, units, mode, off, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (expQ.size() > 0) begin
      e = expQ[0];
      chk(reqValid === 1'b1, {req, " reqValid"}, 64'(reqValid), 64'd1);
      chk(reqAddr === e[31:0], {req, " reqAddr"}, 64'(reqAddr), 64'(e[31:0]));
      chk(reqSize === e[33:32], {req, " reqSize"}, 64'(reqSize), 64'(e[33:32]));
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      reqReady = stall ? lfsr[0] : 1'b1;
      // R12: stray start with another config during the run
      if (midStart && n == 1) begin
        setCfg(32'h0000_0F00, 40, 0, 0, 2, 32'd0, 1'b0);
        start = 1'b1;
      end else start = 1'b0;
      if (reqReady) void'(expQ.pop_front());
      n++;
      @(negedge clk);
    end
    reqReady = 1'b0;
    start    = 1'b0;
    chk(done === 1'b1, "R8 done after last accept", 64'(done), 64'd1);
    chk(busy === 1'b0 && reqValid === 1'b0, "R8 idle with done", 64'({busy, reqValid}), 64'd0);
    @(negedge clk);
    chk(done === 1'b0, "R8 done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    bit err;
    rstN = 1'b0; start = 1'b0; reqReady = 1'b0; errClear = 1'b0;
    setCfg(32'd0, 0, 0, 0, 0, 32'd0, 1'b0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({reqValid, busy, done, sizeErr} === 4'b0, "R1 reset state",
        64'({reqValid, busy, done, sizeErr}), 64'd0);

    runXfer("R2 inc long aligned",   32'h0000_0100, 16, 2, 1, 0, 32'd0, 1'b0, 1'b0);
    runXfer("R2 inc word",           32'h0000_0200, 8,  1, 3, 0, 32'd0, 1'b0, 1'b0);
    runXfer("R7 R12 inc byte stall", 32'h0000_0301, 6,  0, 2, 0, 32'd0, 1'b1, 1'b1);
    runXfer("R3 R4 inc long odd",    32'h0000_0101, 13, 2, 1, 0, 32'd0, 1'b1, 1'b0);
    runXfer("R3 R4 inc long 2mod4",  32'h0000_0202, 11, 2, 1, 0, 32'd0, 1'b0, 1'b0);
    runXfer("R5 R6 dec long masked", 32'h0000_1003, 16, 2, 1, 1, 32'd0, 1'b1, 1'b0);
    runXfer("R5 R6 fixed word",      32'h0000_2001, 6,  1, 1, 2, 32'd0, 1'b0, 1'b0);
    runXfer("R6 offset long",        32'h0000_3002, 12, 2, 1, 3, 32'h40, 1'b0, 1'b0);
    runXfer("R5 dec word odd count", 32'h0000_5000, 5,  1, 0, 1, 32'd0, 1'b0, 1'b0);
    runXfer("R10 fallback dec long", 32'h0000_4003, 6,  2, 1, 1, 32'd0, 1'b1, 1'b0);
    runXfer("R10 fallback ofs word", 32'h0000_6001, 3,  1, 3, 3, 32'h10, 1'b0, 1'b0);

    // R11: zero count, enable clear
    setCfg(32'h10, 0, 1, 0, 0, 32'd0, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1 && reqValid === 1'b0, "R11 zero count done", 64'({done, reqValid}), 64'd2);
    @(negedge clk);
    chk(done === 1'b0 && reqValid === 1'b0, "R11 no request", 64'({done, reqValid}), 64'd0);

    // R9: undersized with enable set
    buildModel(32'h20, 4, 2, 1, 0, 32'd0, 1'b1, err);
    setCfg(32'h20, 4, 2, 1, 0, 32'd0, 1'b1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err && sizeErr === 1'b1, "R9 error raised", 64'(sizeErr), 64'd1);
    for (int i = 0; i < 4; i++) begin
      chk(reqValid === 1'b0 && done === 1'b0 && sizeErr === 1'b1, "R9 no cycles sticky",
          64'({reqValid, done, sizeErr}), 64'd1);
      @(negedge clk);
    end
    // R9: clear and new error in the same cycle
    errClear = 1'b1;
    start    = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    start    = 1'b0;
    chk(sizeErr === 1'b1, "R9 set beats clear", 64'(sizeErr), 64'd1);
    errClear = 1'b1;
    @(negedge clk);
    errClear = 1'b0;
    chk(sizeErr === 1'b0, "R9 cleared", 64'(sizeErr), 64'd0);

    // R1/R2 sequence still works after error handling
    runXfer("R2 inc after error", 32'h0000_0400, 8, 2, 0, 0, 32'd0, 1'b0, 1'b0);

    summary();
    $finish;
  end

endmodule